// File: doc/BRIEF.md
# Interrupt Message Acceptance Filter

This block stands at the entrance of a per-processor interrupt controller. It looks at each incoming interrupt message and decides whether the message is addressed to this processor. It also decides whether the delivery mode is allowed in the current enable state, and how an accepted message is recorded. The block holds a 4-bit physical ID, an 8-bit logical destination set, a software enable flag and the local vector table mask bits. Each of these is written through a simple write strobe.

An accepted fixed or lowest-priority message produces a one-cycle update for its vector. The update marks the vector's request bit and either sets or clears its trigger-mode bit. SMI, NMI, INIT, INIT-deassert and startup messages produce their own one-cycle pulses. The block reports the effective trigger mode of every accepted message, after forcing the edge-only types to edge. When software clears the enable flag, all local mask bits are forced on and stay on. Ordinary messages are then dropped, while the special types still pass. The request and trigger-mode state outside the block receives no updates in that time.

Top module: `msg_accept_filter`

## Requirements
- R1: After reset the enable flag is 0, every bit of `lvt_mask_o` is 1, and every update and pulse output is 0.
- R2: With `msg_dlogical`=0 a message is addressed to the block when `msg_dest[3:0]` equals the 4-bit ID, whatever the upper four bits hold, or when `msg_dest` is 8'hFF. Any other destination is not addressed.
- R3: With `msg_dlogical`=1 a message is addressed to the block when `msg_dest` AND the logical destination register is nonzero.
- R4: Delivery codes are 000 fixed, 001 lowest priority, 010 SMI, 011 remote read, 100 NMI, 101 INIT, 110 startup and 111 reserved. An addressed fixed or lowest-priority message with enable 1 sets bit `msg_vec` of `req_set_o` in the next cycle, and only that bit. In the same cycle it sets the same bit of `tm_set_o` when the effective trigger is level (1). Otherwise it sets that bit of `tm_clr_o`.
- R5: While enable is 0, fixed and lowest-priority messages produce no output. SMI, NMI, INIT and startup messages are still accepted.
- R6: NMI messages, and INIT messages with `msg_deassert`=0, report `acc_level_o`=0 whatever `msg_trig` says. An INIT with `msg_deassert`=1 pulses `deinit_o` instead of `init_o` and reports `msg_trig` unchanged.
- R7: A message with `msg_from_cmd`=1 reports an edge trigger (0), except INIT deassert, which keeps `msg_trig`.
- R8: Remote-read (011) and reserved (111) messages produce no output at all.
- R9: Writing enable to 0 sets every mask bit to 1 on the same edge. Mask writes while disabled are ignored. Writing enable back to 1 leaves the mask bits at 1 until they are rewritten.
- R10: An accepted SMI pulses `smi_o`, NMI pulses `nmi_o`, INIT pulses `init_o`, and startup pulses `sipi_o` with `sipi_vec_o` equal to `msg_vec`. Each pulse lasts one cycle, one cycle after the message, and `acc_level_o` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_we | input | 1 | Enable flag write strobe |
| en_wd | input | 1 | Enable flag write value |
| id_we | input | 1 | ID write strobe |
| id_wd | input | 4 | ID write value |
| ldr_we | input | 1 | Logical destination write strobe |
| ldr_wd | input | 8 | Logical destination write value |
| mask_we | input | 1 | Local mask write strobe |
| mask_wd | input | NLVT | Local mask write value |
| msg_valid | input | 1 | Message present this cycle |
| msg_dmode | input | 3 | Delivery mode code |
| msg_trig | input | 1 | Requested trigger, 1 = level |
| msg_deassert | input | 1 | INIT deassert flag |
| msg_from_cmd | input | 1 | Message raised by the local command register |
| msg_dlogical | input | 1 | Destination mode, 1 = logical |
| msg_dest | input | 8 | Destination field |
| msg_vec | input | VW | Vector |
| req_set_o | output | 2^VW | One-hot request-bit set |
| tm_set_o | output | 2^VW | Trigger-mode bit set |
| tm_clr_o | output | 2^VW | Trigger-mode bit clear |
| nmi_o | output | 1 | NMI pulse |
| smi_o | output | 1 | SMI pulse |
| init_o | output | 1 | INIT pulse |
| deinit_o | output | 1 | INIT deassert pulse |
| sipi_o | output | 1 | Startup pulse |
| sipi_vec_o | output | VW | Startup vector |
| acc_level_o | output | 1 | Effective trigger of the accepted message |
| lvt_mask_o | output | NLVT | Local vector table mask bits |

## Verification
The bench builds the block with its defaults: an 8-bit vector, so 256 update lanes, and six mask bits. With these values the vectors 8'h00 and 8'hFF are both reachable. The broadcast destination and an ID whose nibble sits under nonzero upper destination bits can also be driven directly. Random traffic toggles the enable flag and rewrites ID, logical set and masks between messages. Every delivery code therefore meets both enable states and both destination modes.

// File: rtl/msg_accept_filter.sv
module msg_accept_filter #(
  parameter int VW   = 8,
  parameter int NLVT = 6,
  localparam int NVEC = 1 << VW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_we,
  input  logic            en_wd,
  input  logic            id_we,
  input  logic [3:0]      id_wd,
  input  logic            ldr_we,
  input  logic [7:0]      ldr_wd,
  input  logic            mask_we,
  input  logic [NLVT-1:0] mask_wd,
  input  logic            msg_valid,
  input  logic [2:0]      msg_dmode,
  input  logic            msg_trig,
  input  logic            msg_deassert,
  input  logic            msg_from_cmd,
  input  logic            msg_dlogical,
  input  logic [7:0]      msg_dest,
  input  logic [VW-1:0]   msg_vec,
  output logic [NVEC-1:0] req_set_o,
  output logic [NVEC-1:0] tm_set_o,
  output logic [NVEC-1:0] tm_clr_o,
  output logic            nmi_o,
  output logic            smi_o,
  output logic            init_o,
  output logic            deinit_o,
  output logic            sipi_o,
  output logic [VW-1:0]   sipi_vec_o,
  output logic            acc_level_o,
  output logic [NLVT-1:0] lvt_mask_o
);

  localparam logic [2:0] DM_FIX  = 3'b000;
  localparam logic [2:0] DM_LOW  = 3'b001;
  localparam logic [2:0] DM_SMI  = 3'b010;
  localparam logic [2:0] DM_NMI  = 3'b100;
  localparam logic [2:0] DM_INIT = 3'b101;
  localparam logic [2:0] DM_SIPI = 3'b110;

  logic       en_q;
  logic [3:0] id_q;
  logic [7:0] ldr_q;

  wire hit_phys = (msg_dest == 8'hFF) || (msg_dest[3:0] == id_q);
  wire hit_log  = |(msg_dest & ldr_q);
  wire hit      = msg_valid && (msg_dlogical ? hit_log : hit_phys);

  wire is_fix   = (msg_dmode == DM_FIX) || (msg_dmode == DM_LOW);
  wire is_init  = (msg_dmode == DM_INIT);
  wire init_da  = is_init && msg_deassert;
  wire take_fix = hit && is_fix && en_q;
  wire take_smi = hit && (msg_dmode == DM_SMI);
  wire take_nmi = hit && (msg_dmode == DM_NMI);
  wire take_ini = hit && is_init;
  wire take_sip = hit && (msg_dmode == DM_SIPI);

  wire force_edge = msg_from_cmd || (msg_dmode == DM_NMI) || is_init;
  wire eff_lvl    = msg_trig && (init_da || !force_edge);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      id_q       <= '0;
      ldr_q      <= '0;
      lvt_mask_o <= '1;
    end else begin
      if (en_we) en_q <= en_wd;
      if (id_we) id_q <= id_wd;
      if (ldr_we) ldr_q <= ldr_wd;
      if (en_we && !en_wd) lvt_mask_o <= '1;
      else if (mask_we && en_q) lvt_mask_o <= mask_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_set_o   <= '0;
      tm_set_o    <= '0;
      tm_clr_o    <= '0;
      nmi_o       <= 1'b0;
      smi_o       <= 1'b0;
      init_o      <= 1'b0;
      deinit_o    <= 1'b0;
      sipi_o      <= 1'b0;
      sipi_vec_o  <= '0;
      acc_level_o <= 1'b0;
    end else begin
      req_set_o   <= '0;
      tm_set_o    <= '0;
      tm_clr_o    <= '0;
      if (take_fix) begin
        req_set_o[msg_vec] <= 1'b1;
        if (eff_lvl) tm_set_o[msg_vec] <= 1'b1;
        else         tm_clr_o[msg_vec] <= 1'b1;
      end
      nmi_o       <= take_nmi;
      smi_o       <= take_smi;
      init_o      <= take_ini && !msg_deassert;
      deinit_o    <= take_ini && msg_deassert;
      sipi_o      <= take_sip;
      sipi_vec_o  <= take_sip ? msg_vec : '0;
      acc_level_o <= (take_fix || take_smi || take_nmi || take_ini || take_sip) && eff_lvl;
    end
  end

endmodule

module maf_chk #(
  parameter int VW   = 8,
  parameter int NLVT = 6,
  localparam int NVEC = 1 << VW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            msg_valid,
  input logic [2:0]      msg_dmode,
  input logic            en_q,
  input logic [NLVT-1:0] lvt_mask_o,
  input logic [NVEC-1:0] req_set_o,
  input logic [NVEC-1:0] tm_set_o,
  input logic [NVEC-1:0] tm_clr_o,
  input logic            nmi_o,
  input logic            smi_o,
  input logic            init_o,
  input logic            deinit_o,
  input logic            sipi_o
);

  // R4
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_set_o));

  // R4
  tm_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tm_set_o | tm_clr_o) == req_set_o) && ((tm_set_o & tm_clr_o) == '0));

  // R5
  dis_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !en_q && (msg_dmode[2:1] == 2'b00)) |=> (req_set_o == '0));

  // R8
  rr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_dmode[1:0] == 2'b11)) |=>
      ((req_set_o == '0) && !nmi_o && !smi_o && !init_o && !deinit_o && !sipi_o));

  // R9
  mask_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (&lvt_mask_o));

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({nmi_o, smi_o, init_o, deinit_o, sipi_o, |req_set_o}) <= 1);

endmodule

bind msg_accept_filter maf_chk #(.VW(VW), .NLVT(NLVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_dmode(msg_dmode),
  .en_q(en_q), .lvt_mask_o(lvt_mask_o), .req_set_o(req_set_o),
  .tm_set_o(tm_set_o), .tm_clr_o(tm_clr_o), .nmi_o(nmi_o), .smi_o(smi_o),
  .init_o(init_o), .deinit_o(deinit_o), .sipi_o(sipi_o)
);

// File: tb/sim_msg_accept_filter.sv
module sim_msg_accept_filter;
  localparam int VW = 8;
  localparam int NLVT = 6;
  localparam int NVEC = 1 << VW;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic en_we = 0, en_wd = 0, id_we = 0, ldr_we = 0, mask_we = 0;
  logic [3:0] id_wd = 0;
  logic [7:0] ldr_wd = 0;
  logic [NLVT-1:0] mask_wd = 0;
  logic msg_valid = 0, msg_trig = 0, msg_deassert = 0, msg_from_cmd = 0, msg_dlogical = 0;
  logic [2:0] msg_dmode = 0;
  logic [7:0] msg_dest = 0;
  logic [VW-1:0] msg_vec = 0;
  logic [NVEC-1:0] req_set_o, tm_set_o, tm_clr_o;
  logic nmi_o, smi_o, init_o, deinit_o, sipi_o, acc_level_o;
  logic [VW-1:0] sipi_vec_o;
  logic [NLVT-1:0] lvt_mask_o;

  msg_accept_filter #(.VW(VW), .NLVT(NLVT)) u0 (.*);

  int nchk = 0, nfail = 0;
  bit done = 0;
  bit m_en = 0;
  logic [3:0] m_id = 0;
  logic [7:0] m_ldr = 0;
  logic [NLVT-1:0] m_mask = '1;

  function automatic bit addressed(bit lg, logic [7:0] d);
    if (lg) return |(d & m_ldr);
    return (d == 8'hFF) || (d[3:0] == m_id);
  endfunction

  function automatic bit level_of(logic [2:0] dm, bit tr, bit da, bit fc);
    if (dm == 3'b101 && da) return tr;
    if (fc || dm == 3'b100 || dm == 3'b101) return 0;
    return tr;
  endfunction

  task automatic report(string tag, bit ok, string act, string exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic check_mask(string tag);
    report(tag, lvt_mask_o == m_mask, $sformatf("%h", lvt_mask_o), $sformatf("%h", m_mask));
  endtask

  task automatic wr(int kind, logic [7:0] d);
    @(negedge clk);
    case (kind)
      0: begin en_we = 1; en_wd = d[0]; end
      1: begin id_we = 1; id_wd = d[3:0]; end
      2: begin ldr_we = 1; ldr_wd = d; end
      default: begin mask_we = 1; mask_wd = d[NLVT-1:0]; end
    endcase
    @(negedge clk);
    en_we = 0; id_we = 0; ldr_we = 0; mask_we = 0;
    case (kind)
      0: begin if (!d[0]) m_mask = '1; m_en = d[0]; end
      1: m_id = d[3:0];
      2: m_ldr = d;
      default: if (m_en) m_mask = d[NLVT-1:0];
    endcase
  endtask

  task automatic send(string tag, logic [2:0] dm, bit tr, bit da, bit fc, bit lg,
                      logic [7:0] d, logic [VW-1:0] v);
    logic [NVEC-1:0] e_req, e_ts, e_tc;
    logic [6:0] e_p, a_p;
    logic [VW-1:0] e_sv;
    bit hit, fix, spec, lvl;
    @(negedge clk);
    msg_valid = 1; msg_dmode = dm; msg_trig = tr; msg_deassert = da;
    msg_from_cmd = fc; msg_dlogical = lg; msg_dest = d; msg_vec = v;
    hit = addressed(lg, d);
    fix = hit && m_en && (dm == 3'b000 || dm == 3'b001);
    spec = hit && (dm == 3'b010 || dm == 3'b100 || dm == 3'b101 || dm == 3'b110);
    lvl = level_of(dm, tr, da, fc);
    e_req = '0; e_ts = '0; e_tc = '0;
    if (fix) begin
      e_req[v] = 1;
      if (lvl) e_ts[v] = 1; else e_tc[v] = 1;
    end
    e_p = {spec && dm == 3'b100, spec && dm == 3'b010, spec && dm == 3'b101 && !da,
           spec && dm == 3'b101 && da, spec && dm == 3'b110, 1'b0, (fix || spec) && lvl};
    e_sv = (spec && dm == 3'b110) ? v : '0;
    @(negedge clk);
    a_p = {nmi_o, smi_o, init_o, deinit_o, sipi_o, 1'b0, acc_level_o};
    report(tag, (req_set_o == e_req) && (tm_set_o == e_ts) && (tm_clr_o == e_tc)
                && (a_p == e_p) && (sipi_vec_o == e_sv),
           $sformatf("req=%h ts=%h tc=%h p=%b sv=%h", req_set_o, tm_set_o, tm_clr_o, a_p, sipi_vec_o),
           $sformatf("req=%h ts=%h tc=%h p=%b sv=%h", e_req, e_ts, e_tc, e_p, e_sv));
    msg_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_mask("R1");
    report("R1", (req_set_o == '0) && !nmi_o && !smi_o && !init_o && !deinit_o && !sipi_o && !acc_level_o,
           "outputs nonzero", "all zero");
    wr(0, 1); wr(1, 8'h05); wr(2, 8'h24);
    wr(3, 8'h15); check_mask("R9");
    send("R2", 3'b000, 1, 0, 0, 0, 8'h35, 8'h40);
    send("R4", 3'b001, 0, 0, 0, 0, 8'h05, 8'h00);
    send("R2", 3'b000, 0, 0, 0, 0, 8'hFF, 8'hFF);
    send("R2", 3'b000, 1, 0, 0, 0, 8'h06, 8'h11);
    send("R3", 3'b000, 1, 0, 0, 1, 8'h04, 8'h22);
    send("R3", 3'b000, 1, 0, 0, 1, 8'hDB, 8'h23);
    send("R6", 3'b100, 1, 0, 0, 0, 8'h05, 8'h00);
    send("R6", 3'b101, 1, 0, 0, 0, 8'h05, 8'h00);
    send("R6", 3'b101, 1, 1, 0, 0, 8'h05, 8'h00);
    send("R7", 3'b000, 1, 0, 1, 0, 8'h05, 8'h31);
    send("R7", 3'b101, 1, 1, 1, 0, 8'h05, 8'h00);
    send("R8", 3'b011, 1, 0, 0, 0, 8'h05, 8'h32);
    send("R8", 3'b111, 1, 0, 0, 0, 8'hFF, 8'h33);
    send("R10", 3'b010, 0, 0, 0, 0, 8'h05, 8'h00);
    send("R10", 3'b110, 0, 0, 0, 0, 8'h05, 8'h9A);
    wr(0, 0); check_mask("R9");
    send("R5", 3'b000, 1, 0, 0, 0, 8'h05, 8'h50);
    send("R5", 3'b001, 0, 0, 0, 1, 8'h20, 8'h51);
    send("R5", 3'b100, 0, 0, 0, 0, 8'h05, 8'h00);
    send("R5", 3'b110, 0, 0, 0, 0, 8'hFF, 8'h07);
    wr(3, 8'h00); check_mask("R9");
    wr(0, 1); check_mask("R9");
    wr(3, 8'h2A); check_mask("R9");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      logic [2:0] dm;
      string tag;
      if ($urandom % 16 == 0) begin
        int k = $urandom % 4;
        wr(k, (k == 0) ? 8'((($urandom % 4) != 0)) : 8'($urandom));
        check_mask("R9");
      end
      dm = 3'($urandom);
      case ($urandom % 4)
        0: d = {4'($urandom), m_id};
        1: d = 8'hFF;
        default: d = 8'($urandom);
      endcase
      if (dm[1:0] == 2'b11) tag = "R8";
      else if (dm[2:1] == 2'b00) tag = m_en ? "R4" : "R5";
      else if (dm == 3'b100 || dm == 3'b101) tag = "R6";
      else tag = "R10";
      send(tag, dm, 1'($urandom), 1'($urandom), ($urandom % 4) == 0, 1'($urandom), d, VW'($urandom));
    end
    finish_run();
  end
endmodule